// File: doc/BRIEF.md
# Buffered Cycle/Duty PWM Generator

A 16-bit pulse-width modulation channel built from one counter, a period register, a duty register, and a staging register. The staging register feeds the duty register. The staging value moves into the duty register only at the counter's wrap point. Software can therefore load a new duty at any moment without cutting a pulse short or stretching it. A single mode input picks between two counting schemes.

In sawtooth mode the counter steps 1, 2, ... up to the period value and then reloads to 1. The output goes high at the reload and goes low when the counter meets the duty value. Two duty values are special. When duty equals the period, the output stays high. When duty is zero, the output stays low. A duty of zero is meant to be reached through the staging register. In triangle mode the counter climbs to the period value, falls back to zero, and climbs again. The output toggles at every duty match, which gives a centre-aligned pulse.

Both modes raise a one-cycle event pulse at their wrap point, which an interrupt or DMA engine can use. A status bit shows the current count direction. Taking the run input low freezes the channel where it is.

Top module: `pwm_buf_top`

## Requirements
- R1: After reset, `pwm_o`, `down_o` and `evt_o` are 0, and the counter, period, duty and staging registers all hold 0.
- R2: A write with `wr_en_i`=1 stores `wr_data_i` into a register chosen by `wr_sel_i`: 0 selects the period, 1 the duty, 2 the staging register, and 3 selects nothing. In sawtooth mode (`mode_i`=0) with `run_i`=1, the counter steps by one per clock. When it reaches the period value P, it reloads to 1 on the next clock, and `evt_o` is high for exactly one clock. Successive pulses are P clocks apart.
- R3: In sawtooth mode with 0 < duty < P, the output rises on the reload and falls on the clock after the counter equals duty. It is therefore high for exactly duty clocks in every period.
- R4: The staging value is copied into the duty register only at the sawtooth reload. A staging write made during a period leaves that period's high time unchanged and sets the high time of the next period.
- R5: In sawtooth mode, a duty equal to P keeps `pwm_o` high for every clock of the period (100%).
- R6: In sawtooth mode, a zero duty taken from the staging register keeps `pwm_o` low for every clock of the period (0%).
- R7: In triangle mode (`mode_i`=1), the counter rises from 0 to P and then falls back to 0, so one period lasts 2·P clocks. `evt_o` pulses for one clock after the counter reaches 0 while falling. `down_o` is 1 for exactly P clocks of each period. The staging value is copied into the duty register at that same zero point.
- R8: In triangle mode, `pwm_o` toggles on the clock after the counter equals duty. Starting from reset with 0 < duty < P, the output is high for 2·(P − duty) clocks of each period.
- R9: While `run_i`=0, the counter and output hold their values and `evt_o` stays 0. After `run_i` returns to 1, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Count enable (start bit) |
| mode_i | input | 1 | 0 sawtooth, 1 triangle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 period, 1 duty, 2 staging |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | Waveform output |
| down_o | output | 1 | 1 while the counter is falling |
| evt_o | output | 1 | One-clock pulse at the wrap point |

## Verification
The bench measures high time and event spacing over whole periods. A design that applied staging writes immediately would show the new duty in a period that is already running. A design that forgot the 100% case would let the output drop for one clock per period, and one that forgot the 0% case would let it rise for one clock at the reload. In triangle mode the bench checks the 2·P period, the direction-flag count and the symmetric high time. A wrong turnaround would stretch the period by a clock or shift the pulse off centre. Freezing is checked by counting the exact number of clocks to the next event after resume, so a counter that crept forward while stopped would arrive early.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_STAGE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    MODE_SAW = 1'b0,
    MODE_TRI = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_buf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] stage_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      stage_o  <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_PERIOD) period_o <= wr_data_i;
      if (sel == SEL_STAGE)  stage_o  <= wr_data_i;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_buf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         mode_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         wrap_o,
  output logic         evt_o
);
  localparam logic [W-1:0] One = W'(1);

  cnt_mode_e mode;
  logic      at_zero;
  logic      at_top;

  assign mode    = cnt_mode_e'(mode_i);
  assign at_zero = (cnt_o == '0);
  assign at_top  = (cnt_o >= period_i);
  // wrap point: sawtooth top, or triangle trough while falling
  assign wrap_o  = (mode == MODE_TRI) ? (down_o && at_zero) : at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      down_o <= 1'b0;
      evt_o  <= 1'b0;
    end else if (run_i) begin
      evt_o <= wrap_o;
      if (mode == MODE_SAW) begin
        down_o <= 1'b0;
        cnt_o  <= wrap_o ? One : cnt_o + One;
      end else if (!down_o) begin
        if (at_top) begin
          down_o <= 1'b1;
          cnt_o  <= at_zero ? '0 : cnt_o - One;
        end else begin
          cnt_o <= cnt_o + One;
        end
      end else if (at_zero) begin
        down_o <= 1'b0;
        cnt_o  <= One;
      end else begin
        cnt_o <= cnt_o - One;
      end
    end else begin
      evt_o <= 1'b0;
    end
  end

  // R9
  hold_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !evt_o);
  // R9
  hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_o));
  // R7
  tri_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i && down_o && at_zero) |=> (!down_o && evt_o));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_buf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         mode_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] stage_i,
  input  logic         wrap_i,
  output logic         pwm_o
);
  logic [W-1:0] duty_q;
  logic         duty_hit;
  logic         duty_wr;

  assign duty_hit = (cnt_i == duty_q);
  assign duty_wr  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_DUTY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      if (run_i) begin
        if (wrap_i) duty_q <= stage_i;
        if (cnt_mode_e'(mode_i) == MODE_SAW) begin
          if (wrap_i)                              pwm_o <= (stage_i != '0);
          else if (duty_hit && duty_q != period_i) pwm_o <= 1'b0;
        end else if (duty_hit) begin
          pwm_o <= ~pwm_o;
        end
      end
      if (duty_wr) duty_q <= wr_data_i;
    end
  end

  // R3
  saw_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !mode_i && !wrap_i && duty_hit && duty_q != period_i) |=> !pwm_o);
  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !mode_i && !wrap_i && pwm_o && duty_q == period_i && !duty_wr) |=> pwm_o);
  // R6
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !mode_i && !pwm_o && duty_q == '0 && stage_i == '0) |=> !pwm_o);
  // R9
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pwm_o));
endmodule

// File: rtl/pwm_buf_top.sv
module pwm_buf_top #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         mode_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic         pwm_o,
  output logic         down_o,
  output logic         evt_o
);
  logic [W-1:0] period;
  logic [W-1:0] stage;
  logic [W-1:0] cnt;
  logic         wrap;

  pwm_cfg_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .period_o(period), .stage_o(stage)
  );

  pwm_timebase #(.W(W)) u_tb (
    .clk_i, .rst_ni, .run_i, .mode_i,
    .period_i(period), .cnt_o(cnt), .down_o(down_o),
    .wrap_o(wrap), .evt_o(evt_o)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk_i, .rst_ni, .run_i, .mode_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .cnt_i(cnt), .period_i(period), .stage_i(stage), .wrap_i(wrap),
    .pwm_o(pwm_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!pwm_o && !down_o && !evt_o));
endmodule

// File: tb/pwm_buf_top_test.sv
module pwm_buf_top_test;
  localparam int ClkPeriod = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic         mode = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pwm, down, evt;

  int n_tests = 0;
  int n_fail  = 0;

  always #(ClkPeriod/2) clk = ~clk;

  pwm_buf_top #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .mode_i(mode),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .pwm_o(pwm), .down_o(down), .evt_o(evt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    run = 1'b0; mode = 1'b0; wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_evt();
    int guard = 0;
    while (!evt && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // From a negedge where evt=1: count one period up to the next evt.
  task automatic measure(input logic stage_wr, input int stage_val,
                         output int hi, output int per, output int dn);
    hi = 0; per = 0; dn = 0;
    do begin
      if (pwm)  hi++;
      if (down) dn++;
      if (per == 0 && stage_wr) begin
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = W'(stage_val);
      end
      per++;
      @(negedge clk);
      wr_en = 1'b0;
    end while (!evt && per < 2000);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pwm", int'(pwm), 0);
    check("R1 down", int'(down), 0);
    check("R1 evt", int'(evt), 0);
  endtask

  task automatic t_saw();
    int hi, per, dn;
    do_reset();
    wr(2'd0, 10); wr(2'd2, 3);
    run = 1'b1;
    @(negedge clk); sync_evt();
    measure(1'b0, 0, hi, per, dn);
    check("R2 period", per, 10);
    check("R3 high time", hi, 3);
    check("R2 down flag", dn, 0);
    measure(1'b1, 7, hi, per, dn);
    check("R4 old duty kept", hi, 3);
    measure(1'b0, 0, hi, per, dn);
    check("R4 new duty", hi, 7);
    check("R2 period after update", per, 10);
  endtask

  task automatic t_full();
    int hi, per, dn;
    do_reset();
    wr(2'd0, 10); wr(2'd2, 10);
    run = 1'b1;
    @(negedge clk); sync_evt();
    measure(1'b0, 0, hi, per, dn);
    measure(1'b0, 0, hi, per, dn);
    check("R5 full high", hi, 10);
    check("R5 period", per, 10);
  endtask

  task automatic t_zero();
    int hi, per, dn;
    do_reset();
    wr(2'd0, 10); wr(2'd2, 4);
    run = 1'b1;
    @(negedge clk); sync_evt();
    measure(1'b1, 0, hi, per, dn);
    check("R6 previous duty", hi, 4);
    measure(1'b0, 0, hi, per, dn);
    check("R6 zero high", hi, 0);
    measure(1'b0, 0, hi, per, dn);
    check("R6 stays zero", hi, 0);
  endtask

  task automatic t_tri(input int p, input int d);
    int hi, per, dn;
    do_reset();
    wr(2'd0, p); wr(2'd2, d);
    mode = 1'b1;
    run = 1'b1;
    @(negedge clk); sync_evt();
    measure(1'b0, 0, hi, per, dn);
    check("R7 tri period", per, 2 * p);
    check("R7 down count", dn, p);
    check("R8 tri high", hi, 2 * (p - d));
    measure(1'b0, 0, hi, per, dn);
    check("R8 tri high repeat", hi, 2 * (p - d));
  endtask

  task automatic t_freeze();
    int hi, per, dn, bad, steps;
    logic held;
    do_reset();
    wr(2'd0, 10); wr(2'd2, 3);
    run = 1'b1;
    @(negedge clk); sync_evt();
    measure(1'b0, 0, hi, per, dn);
    repeat (2) @(negedge clk);  // counter now at 3
    run = 1'b0;
    @(negedge clk);
    held = pwm;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (evt || pwm != held) bad++;
      @(negedge clk);
    end
    check("R9 frozen", bad, 0);
    run = 1'b1;
    steps = 0;
    do begin
      @(negedge clk);
      steps++;
    end while (!evt && steps < 100);
    check("R9 resume point", steps, 8);
  endtask

  initial begin
    t_reset();
    t_saw();
    t_full();
    t_zero();
    t_tri(4, 1);
    t_tri(6, 2);
    t_freeze();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule